// File: doc/BRIEF.md
# Two-Channel Striping Data Switch

This block spreads one 256-bit user data stream over two channel FIFOs in 512-byte stripes and, in the read direction, collects the stripes back into one stream in the same order. Each stripe is 16 beats. The low bit of the current stripe address picks the channel, so consecutive stripes alternate between channel 0 and channel 1. The block starts a stripe only when the FIFO that supplies the data holds a full stripe and the FIFO that takes the data has room for two stripes. It learns both facts from the fill-level counters of those FIFOs.

A command is made of a direction, a 48-bit start address and a 48-bit length, both counted in stripes. It is handed over with a request/busy handshake. When the command is accepted, the block also works out the start address and the stripe count that each channel's storage controller must handle. The controllers themselves are outside this block. They appear only as a busy input per channel, and the end of a read waits on those inputs.

Top module: `stripe_switch`

## Requirements
- R1: After reset `busy_o` is 0 and every enable output is 0. A high `req_i` is accepted only while `busy_o` is 0, and `busy_o` is 1 in the cycle after the accepting edge. A request raised while `busy_o` is 1 changes neither the transfer in progress nor the per-channel outputs.
- R2: Stripe number s of a command (counting from 0) uses channel `(addr_i + s) & 1`. `cmd_i` = 0 means write and `cmd_i` = 1 means read.
- R3: A write stripe starts only when `usr_rd_cnt_i` >= 16 and the active channel's `tx_wr_cnt_i` field is <= FIFO_DEPTH-32, which means at least 32 free beats. Channel c's field is bits [16c+15:16c].
- R4: A read stripe starts only when the active channel's `rx_rd_cnt_i` field is >= 16 and `usr_wr_cnt_i` is <= FIFO_DEPTH-32. The field layout is the same as in R3.
- R5: Each stripe holds its source read enable high for exactly 16 consecutive cycles. The beat read under an enable in cycle t appears at the destination write port in cycle t+2, on the channel of that stripe, with its data unchanged.
- R6: On a write, if `usr_rd_cnt_i` >= 32 at the last beat of a stripe, the next stripe's enable starts after one idle cycle. Otherwise it starts after four idle cycles.
- R7: On a read, after the last stripe `busy_o` stays 1 while any bit of `ch_busy_i` is 1. It falls one cycle after `ch_busy_i` becomes 0.
- R8: At acceptance, channel c gets a start address of `(addr + ((c ^ addr[0]) & 1)) >> 1` and a length equal to the number of stripes in the command that map to channel c. These appear on fields [48c+47:48c] of `ch_addr_o` and `ch_len_o`.
- R9: A write ends once all stripes are issued, and `busy_o` then falls. A command with zero length moves no data and returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Command request |
| cmd_i | input | 1 | 0 write, 1 read |
| addr_i | input | 48 | Start address in stripes |
| len_i | input | 48 | Length in stripes |
| busy_o | output | 1 | Command in progress |
| usr_rd_cnt_i | input | 16 | User source FIFO fill level, beats |
| usr_rd_en_o | output | 1 | User source FIFO read enable |
| usr_rd_data_i | input | 256 | User source data, valid one cycle after enable |
| usr_wr_cnt_i | input | 16 | User sink FIFO fill level, beats |
| usr_wr_en_o | output | 1 | User sink FIFO write enable |
| usr_wr_data_o | output | 256 | User sink write data |
| tx_wr_cnt_i | input | 32 | Channel transmit FIFO fill levels, 16 bits each |
| tx_wr_en_o | output | 2 | Channel transmit FIFO write enables |
| tx_wr_data_o | output | 256 | Channel transmit write data |
| rx_rd_cnt_i | input | 32 | Channel receive FIFO fill levels, 16 bits each |
| rx_rd_en_o | output | 2 | Channel receive FIFO read enables |
| rx_rd_data_i | input | 512 | Channel receive data, 256 bits each |
| ch_busy_i | input | 2 | Channel controllers busy |
| ch_addr_o | output | 96 | Per-channel start addresses |
| ch_len_o | output | 96 | Per-channel lengths |

## Verification
The bench uses the default parameters: 256-bit beats, 16-beat stripes, a FIFO depth of 512 beats and 48-bit address and length. With these values the start thresholds sit at 16 and 480 beats, so the bench can drive each counter one step below and one step above its threshold and see a stripe held back or released. Short commands at both address parities exercise both channel orders and the odd/even length split. Source counts on either side of 32 produce both the chained gap and the settling gap between write stripes.

// File: rtl/stripe_pkg.sv
package stripe_pkg;
  localparam int unsigned NCH = 2;
  localparam logic CMD_WR = 1'b0;
  localparam logic CMD_RD = 1'b1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_DATA,
    ST_XFER,
    ST_WAIT_FIFO,
    ST_WAIT_END
  } sw_state_e;
endpackage

// File: rtl/stripe_split.sv
module stripe_split
  import stripe_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned LEN_W  = 48
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  accept_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [LEN_W-1:0]      len_i,
  output logic [NCH*ADDR_W-1:0] ch_addr_o,
  output logic [NCH*LEN_W-1:0]  ch_len_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic              lead;
    logic [ADDR_W:0]   addr_ext;
    logic [LEN_W:0]    len_ext;

    // lead: this channel owns the first stripe
    assign lead     = (addr_i[0] == 1'(c));
    assign addr_ext = ({1'b0, addr_i} + (ADDR_W+1)'(!lead)) >> 1;
    assign len_ext  = ({1'b0, len_i} + (LEN_W+1)'(lead)) >> 1;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ch_addr_o[c*ADDR_W +: ADDR_W] <= '0;
        ch_len_o[c*LEN_W +: LEN_W]    <= '0;
      end else if (accept_i) begin
        ch_addr_o[c*ADDR_W +: ADDR_W] <= addr_ext[ADDR_W-1:0];
        ch_len_o[c*LEN_W +: LEN_W]    <= len_ext[LEN_W-1:0];
      end
    end
  end
endmodule

// File: rtl/stripe_ctrl.sv
module stripe_ctrl
  import stripe_pkg::*;
#(
  parameter int unsigned LEN_W        = 48,
  parameter int unsigned CNT_W        = 16,
  parameter int unsigned STRIPE_BEATS = 16,
  parameter int unsigned FIFO_DEPTH   = 512,
  parameter int unsigned SETTLE_CYC   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               cmd_i,
  input  logic               addr_lsb_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [CNT_W-1:0]   usr_src_cnt_i,
  input  logic [CNT_W-1:0]   usr_snk_cnt_i,
  input  logic [NCH*CNT_W-1:0] tx_cnt_i,
  input  logic [NCH*CNT_W-1:0] rx_cnt_i,
  input  logic [NCH-1:0]     ch_busy_i,
  output logic               busy_o,
  output logic               accept_o,
  output logic               cmd_o,
  output logic               xfer_o,
  output logic               chsel_o
);
  localparam int unsigned BEAT_W  = $clog2(STRIPE_BEATS);
  localparam int unsigned WAIT_W  = $clog2(SETTLE_CYC + 1);
  localparam int unsigned ROOM_MAX = FIFO_DEPTH - 2 * STRIPE_BEATS;

  sw_state_e          state_q;
  logic               cmd_q;
  logic [LEN_W-1:0]   rem_q;
  logic               chsel_q;
  logic [BEAT_W-1:0]  beat_q;
  logic [WAIT_W-1:0]  wait_q;
  logic [CNT_W-1:0]   ch_cnt_q;
  logic               nxt_ch;
  logic               cmd_eff;
  logic               start_ok;
  logic               last_beat;

  // channel whose count the next stripe check will see
  always_comb begin
    if (state_q == ST_IDLE)      nxt_ch = addr_lsb_i;
    else if (state_q == ST_XFER) nxt_ch = ~chsel_q;
    else                         nxt_ch = chsel_q;
  end
  assign cmd_eff = (state_q == ST_IDLE) ? cmd_i : cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ch_cnt_q <= '0;
    else if (cmd_eff == CMD_RD) ch_cnt_q <= rx_cnt_i[nxt_ch*CNT_W +: CNT_W];
    else                        ch_cnt_q <= tx_cnt_i[nxt_ch*CNT_W +: CNT_W];
  end

  assign start_ok = (cmd_q == CMD_WR)
      ? (usr_src_cnt_i >= CNT_W'(STRIPE_BEATS) && ch_cnt_q <= CNT_W'(ROOM_MAX))
      : (ch_cnt_q >= CNT_W'(STRIPE_BEATS) && usr_snk_cnt_i <= CNT_W'(ROOM_MAX));
  assign last_beat = (beat_q == BEAT_W'(STRIPE_BEATS - 1));
  assign accept_o  = (state_q == ST_IDLE) && req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= CMD_WR;
      rem_q   <= '0;
      chsel_q <= 1'b0;
      beat_q  <= '0;
      wait_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          cmd_q   <= cmd_i;
          rem_q   <= len_i;
          chsel_q <= addr_lsb_i;
          state_q <= ST_WAIT_DATA;
        end
        ST_WAIT_DATA: begin
          if (rem_q == '0) begin
            state_q <= (cmd_q == CMD_RD) ? ST_WAIT_END : ST_IDLE;
          end else if (start_ok) begin
            beat_q  <= '0;
            state_q <= ST_XFER;
          end
        end
        ST_XFER: begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) begin
            chsel_q <= ~chsel_q;
            rem_q   <= rem_q - 1'b1;
            wait_q  <= '0;
            if (cmd_q == CMD_RD || usr_src_cnt_i >= CNT_W'(2 * STRIPE_BEATS))
              state_q <= ST_WAIT_DATA;
            else
              state_q <= ST_WAIT_FIFO;
          end
        end
        ST_WAIT_FIFO: begin
          wait_q <= wait_q + 1'b1;
          if (wait_q == WAIT_W'(SETTLE_CYC - 1)) state_q <= ST_WAIT_DATA;
        end
        ST_WAIT_END: if (ch_busy_i == '0) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign cmd_o   = cmd_q;
  assign xfer_o  = (state_q == ST_XFER);
  assign chsel_o = chsel_q;

  // R1
  busy_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_i));
  // R5
  stripe_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(xfer_o) |-> $past(beat_q) == BEAT_W'(STRIPE_BEATS - 1));
  // R2
  ch_alternate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(xfer_o) |-> chsel_q != $past(chsel_q));
  // R7
  end_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_END && ch_busy_i != '0) |=> busy_o);
  // R9
  no_underrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> rem_q != '0);
endmodule

// File: rtl/stripe_route.sv
module stripe_route
  import stripe_pkg::*;
#(
  parameter int unsigned DATA_W = 256
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  xfer_i,
  input  logic                  cmd_i,
  input  logic                  chsel_i,
  output logic                  usr_rd_en_o,
  input  logic [DATA_W-1:0]     usr_rd_data_i,
  output logic [NCH-1:0]        tx_wr_en_o,
  output logic [DATA_W-1:0]     tx_wr_data_o,
  output logic [NCH-1:0]        rx_rd_en_o,
  input  logic [NCH*DATA_W-1:0] rx_rd_data_i,
  output logic                  usr_wr_en_o,
  output logic [DATA_W-1:0]     usr_wr_data_o
);
  logic en_d1;
  logic sel_d1;

  assign usr_rd_en_o = xfer_i && (cmd_i == CMD_WR);
  for (genvar c = 0; c < NCH; c++) begin : g_rx_en
    assign rx_rd_en_o[c] = xfer_i && (cmd_i == CMD_RD) && (chsel_i == 1'(c));
  end

  // stage 1: enable/select follow the FIFO read latency; stage 2: registered outputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_d1         <= 1'b0;
      sel_d1        <= 1'b0;
      tx_wr_en_o    <= '0;
      tx_wr_data_o  <= '0;
      usr_wr_en_o   <= 1'b0;
      usr_wr_data_o <= '0;
    end else begin
      en_d1       <= xfer_i;
      sel_d1      <= chsel_i;
      tx_wr_en_o  <= (en_d1 && cmd_i == CMD_WR) ? (NCH'(1) << sel_d1) : '0;
      usr_wr_en_o <= en_d1 && (cmd_i == CMD_RD);
      if (en_d1 && cmd_i == CMD_WR) tx_wr_data_o <= usr_rd_data_i;
      if (en_d1 && cmd_i == CMD_RD) usr_wr_data_o <= rx_rd_data_i[sel_d1*DATA_W +: DATA_W];
    end
  end

  // R5
  tx_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tx_wr_en_o));
  // R5
  rx_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rx_rd_en_o));
  // R5
  tx_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wr_en_o != '0) |-> $past(usr_rd_en_o, 2));
  // R5
  rx_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usr_wr_en_o |-> $past(rx_rd_en_o != '0, 2));
endmodule

// File: rtl/stripe_switch.sv
module stripe_switch
  import stripe_pkg::*;
#(
  parameter int unsigned DATA_W       = 256,
  parameter int unsigned ADDR_W       = 48,
  parameter int unsigned LEN_W        = 48,
  parameter int unsigned CNT_W        = 16,
  parameter int unsigned STRIPE_BEATS = 16,
  parameter int unsigned FIFO_DEPTH   = 512,
  parameter int unsigned SETTLE_CYC   = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   cmd_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [LEN_W-1:0]       len_i,
  output logic                   busy_o,
  input  logic [CNT_W-1:0]       usr_rd_cnt_i,
  output logic                   usr_rd_en_o,
  input  logic [DATA_W-1:0]      usr_rd_data_i,
  input  logic [CNT_W-1:0]       usr_wr_cnt_i,
  output logic                   usr_wr_en_o,
  output logic [DATA_W-1:0]      usr_wr_data_o,
  input  logic [2*CNT_W-1:0]     tx_wr_cnt_i,
  output logic [1:0]             tx_wr_en_o,
  output logic [DATA_W-1:0]      tx_wr_data_o,
  input  logic [2*CNT_W-1:0]     rx_rd_cnt_i,
  output logic [1:0]             rx_rd_en_o,
  input  logic [2*DATA_W-1:0]    rx_rd_data_i,
  input  logic [1:0]             ch_busy_i,
  output logic [2*ADDR_W-1:0]    ch_addr_o,
  output logic [2*LEN_W-1:0]     ch_len_o
);
  logic accept;
  logic cmd_q;
  logic xfer;
  logic chsel;

  stripe_ctrl #(
    .LEN_W(LEN_W), .CNT_W(CNT_W), .STRIPE_BEATS(STRIPE_BEATS),
    .FIFO_DEPTH(FIFO_DEPTH), .SETTLE_CYC(SETTLE_CYC)
  ) u_ctrl (
    .clk_i, .rst_ni, .req_i, .cmd_i,
    .addr_lsb_i   (addr_i[0]),
    .len_i,
    .usr_src_cnt_i(usr_rd_cnt_i),
    .usr_snk_cnt_i(usr_wr_cnt_i),
    .tx_cnt_i     (tx_wr_cnt_i),
    .rx_cnt_i     (rx_rd_cnt_i),
    .ch_busy_i,
    .busy_o,
    .accept_o     (accept),
    .cmd_o        (cmd_q),
    .xfer_o       (xfer),
    .chsel_o      (chsel)
  );

  stripe_route #(.DATA_W(DATA_W)) u_route (
    .clk_i, .rst_ni,
    .xfer_i   (xfer),
    .cmd_i    (cmd_q),
    .chsel_i  (chsel),
    .usr_rd_en_o, .usr_rd_data_i,
    .tx_wr_en_o, .tx_wr_data_o,
    .rx_rd_en_o, .rx_rd_data_i,
    .usr_wr_en_o, .usr_wr_data_o
  );

  stripe_split #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_split (
    .clk_i, .rst_ni,
    .accept_i (accept),
    .addr_i, .len_i,
    .ch_addr_o, .ch_len_o
  );
endmodule

// File: tb/sim_stripe_switch.sv
`timescale 1ns/1ps
module sim_stripe_switch;
  localparam int W = 256;
  localparam int DEPTH = 512;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0, cmd_i = 1'b0;
  logic [47:0] addr_i = '0, len_i = '0;
  logic busy_o;
  logic [15:0] usr_rd_cnt_i = '0, usr_wr_cnt_i = '0;
  logic usr_rd_en_o, usr_wr_en_o;
  logic [W-1:0] usr_rd_data_i = '0, usr_wr_data_o, tx_wr_data_o;
  logic [31:0] tx_wr_cnt_i = '0, rx_rd_cnt_i = '0;
  logic [1:0] tx_wr_en_o, rx_rd_en_o, ch_busy_i = '0;
  logic [2*W-1:0] rx_rd_data_i = '0;
  logic [95:0] ch_addr_o, ch_len_o;

  always #4 clk_i = ~clk_i;

  stripe_switch u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int cyc = 0;
  logic op_rd;
  logic [47:0] op_addr;
  int op_len, exp_gap;
  logic [31:0] op_seed = 0;
  int wr_k, rd_k, src_idx, run_len, last_en, stripes;
  int rx_idx[2];
  bit src_pend, en_prev;
  bit rx_pend[2];

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] wpat(input logic [31:0] s, input int k);
    logic [W-1:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = s ^ (32'(k * 8 + i) * 32'h9E3779B1);
    return r;
  endfunction

  function automatic logic [W-1:0] rpat(input logic [31:0] s, input int c, input int k);
    return wpat(s ^ (32'(c + 1) << 24), k);
  endfunction

  // FIFO models and output checks
  always @(negedge clk_i) begin
    bit en_now;
    cyc++;
    if (src_pend) begin usr_rd_data_i = wpat(op_seed, src_idx); src_idx++; end
    src_pend = usr_rd_en_o;
    for (int c = 0; c < 2; c++) begin
      if (rx_pend[c]) begin rx_rd_data_i[c*W +: W] = rpat(op_seed, c, rx_idx[c]); rx_idx[c]++; end
      rx_pend[c] = rx_rd_en_o[c];
    end
    if (tx_wr_en_o != 0) begin
      int ch;
      ch = int'((op_addr + 48'(wr_k / 16)) & 48'd1);
      chk(tx_wr_en_o == (2'b01 << ch), "R2 tx channel", W'(tx_wr_en_o), W'(2'b01 << ch));
      chk(tx_wr_data_o == wpat(op_seed, wr_k), "R5 tx data", tx_wr_data_o, wpat(op_seed, wr_k));
      wr_k++;
    end
    if (usr_wr_en_o) begin
      int s, ch, idx;
      s = rd_k / 16;
      ch = int'((op_addr + 48'(s)) & 48'd1);
      idx = (s / 2) * 16 + rd_k % 16;
      chk(usr_wr_data_o == rpat(op_seed, ch, idx), "R2 read gather", usr_wr_data_o, rpat(op_seed, ch, idx));
      rd_k++;
    end
    en_now = usr_rd_en_o | (|rx_rd_en_o);
    if (en_now && !en_prev && stripes > 0 && !op_rd)
      chk(cyc - last_en - 1 == exp_gap, "R6 stripe gap", W'(cyc - last_en - 1), W'(exp_gap));
    if (en_now) begin run_len++; last_en = cyc; end
    if (!en_now && en_prev) begin
      chk(run_len == 16, "R5 enable run", W'(run_len), W'(16));
      run_len = 0;
      stripes++;
    end
    en_prev = en_now;
  end

  task automatic start_op(input logic rd, input logic [47:0] a, input int len);
    @(negedge clk_i);
    op_rd = rd; op_addr = a; op_len = len; op_seed = $urandom;
    wr_k = 0; rd_k = 0; src_idx = 0; rx_idx[0] = 0; rx_idx[1] = 0;
    run_len = 0; stripes = 0;
    exp_gap = (usr_rd_cnt_i >= 32) ? 1 : 4;
    cmd_i = rd; addr_i = a; len_i = 48'(len); req_i = 1'b1;
    @(negedge clk_i);
    chk(busy_o == 1'b1, "R1 busy after req", W'(busy_o), W'(1));
    for (int c = 0; c < 2; c++) begin
      logic [48:0] ea;
      int el;
      el = 0;
      for (int s = 0; s < len; s++) if (((a + 48'(s)) & 48'd1) == 48'(c)) el++;
      ea = ({1'b0, a} + 49'((c ^ int'(a[0])) & 1)) >> 1;
      chk(ch_addr_o[c*48 +: 48] == ea[47:0], "R8 channel address", W'(ch_addr_o[c*48 +: 48]), W'(ea[47:0]));
      chk(ch_len_o[c*48 +: 48] == 48'(el), "R8 channel length", W'(ch_len_o[c*48 +: 48]), W'(el));
    end
    req_i = 1'b0;
  endtask

  task automatic wait_done();
    int t;
    t = 0;
    while (busy_o && t < 5000) begin @(negedge clk_i); t++; end
    chk(t < 5000, "R9 completion", W'(t), W'(0));
    repeat (3) @(negedge clk_i);
    if (op_rd) chk(rd_k == op_len * 16, "R5 read beats", W'(rd_k), W'(op_len * 16));
    else       chk(wr_k == op_len * 16, "R9 write beats", W'(wr_k), W'(op_len * 16));
  endtask

  task automatic set_ready(input int src, input int snk);
    usr_rd_cnt_i = 16'(src); usr_wr_cnt_i = 16'(snk);
    tx_wr_cnt_i = '0; rx_rd_cnt_i = {16'd200, 16'd200}; ch_busy_i = '0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk_i);
    chk(busy_o == 0 && tx_wr_en_o == 0 && rx_rd_en_o == 0 && !usr_rd_en_o && !usr_wr_en_o,
        "R1 reset state", W'({busy_o, tx_wr_en_o, rx_rd_en_o}), W'(0));
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // chained write, even start
    set_ready(40, 0);
    start_op(1'b0, 48'h10, 4); wait_done();
    // settle-gap write, odd start
    set_ready(20, 0);
    start_op(1'b0, 48'h2F, 5); wait_done();

    // R3: source one beat short
    set_ready(15, 0);
    start_op(1'b0, 48'h40, 2);
    repeat (30) @(negedge clk_i);
    chk(wr_k == 0 && src_idx == 0 && busy_o, "R3 source short", W'(src_idx), W'(0));
    usr_rd_cnt_i = 16'd16;
    wait_done();
    // R3: transmit FIFO room one beat short on channel 1
    set_ready(40, 0);
    tx_wr_cnt_i = {16'(DEPTH - 31), 16'd0};
    start_op(1'b0, 48'h41, 2);
    repeat (30) @(negedge clk_i);
    chk(src_idx == 0 && busy_o, "R3 tx room short", W'(src_idx), W'(0));
    tx_wr_cnt_i = {16'(DEPTH - 32), 16'd0};
    wait_done();

    // R4: receive FIFO one beat short on channel 0
    set_ready(0, 0);
    rx_rd_cnt_i = {16'd16, 16'd15};
    start_op(1'b1, 48'h8, 3);
    repeat (30) @(negedge clk_i);
    chk(rx_idx[0] == 0 && rx_idx[1] == 0 && busy_o, "R4 rx short", W'(rx_idx[0]), W'(0));
    rx_rd_cnt_i = {16'd16, 16'd16};
    wait_done();
    // R4: user sink room one beat short
    set_ready(0, DEPTH - 31);
    start_op(1'b1, 48'h9, 2);
    repeat (30) @(negedge clk_i);
    chk(rx_idx[0] == 0 && rx_idx[1] == 0 && busy_o, "R4 sink room short", W'(rx_idx[1]), W'(0));
    usr_wr_cnt_i = 16'(DEPTH - 32);
    wait_done();

    // R7: channel still busy after last stripe
    set_ready(0, 0);
    ch_busy_i = 2'b01;
    start_op(1'b1, 48'h3, 3);
    begin
      int t;
      t = 0;
      while (rd_k < 48 && t < 2000) begin @(negedge clk_i); t++; end
    end
    repeat (8) @(negedge clk_i);
    chk(busy_o == 1'b1, "R7 busy held", W'(busy_o), W'(1));
    ch_busy_i = 2'b00;
    @(negedge clk_i);
    chk(busy_o == 1'b0, "R7 busy released", W'(busy_o), W'(0));
    chk(rd_k == 48, "R7 read beats", W'(rd_k), W'(48));

    // R9: zero length
    set_ready(40, 0);
    start_op(1'b0, 48'h5, 0); wait_done();

    // R1: request while busy is ignored
    set_ready(40, 0);
    start_op(1'b0, 48'h22, 3);
    repeat (5) @(negedge clk_i);
    cmd_i = 1'b1; addr_i = 48'h777; len_i = 48'd9; req_i = 1'b1;
    repeat (3) @(negedge clk_i);
    req_i = 1'b0;
    chk(ch_addr_o[47:0] == 48'h11 && ch_len_o[47:0] == 48'd2, "R1 request while busy",
        W'(ch_addr_o[47:0]), W'(48'h11));
    wait_done();
    repeat (3) @(negedge clk_i);
    chk(busy_o == 1'b0, "R1 no late accept", W'(busy_o), W'(0));

    // random commands
    for (int n = 0; n < 14; n++) begin
      logic [63:0] r64;
      logic rd;
      r64 = {$urandom, $urandom};
      rd = 1'($urandom % 2);
      usr_rd_cnt_i = 16'(16 + $urandom % 30);
      usr_wr_cnt_i = 16'($urandom % (DEPTH - 31));
      tx_wr_cnt_i = {16'($urandom % (DEPTH - 31)), 16'($urandom % (DEPTH - 31))};
      rx_rd_cnt_i = {16'(16 + $urandom % 100), 16'(16 + $urandom % 100)};
      ch_busy_i = '0;
      start_op(rd, r64[47:0], int'(1 + $urandom % 6));
      wait_done();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule